// File: doc/BRIEF.md
# Receive-Level Handshake Controller with Hysteresis

This block decides the level of an active-low modem handshake pin from the fill count of a receive FIFO. The pin can serve as request-to-send or as data-terminal-ready. When the FIFO fills up to a configurable trigger level plus a hysteresis margin, the block raises the pin so that the remote transmitter pauses. It lowers the pin again only after the level has drained to the trigger minus the same margin. Because the pin switches at two different levels, a FIFO level that wobbles near the trigger does not make the pin toggle.

Automatic control is active only while both an extended-feature enable and a modem-control enable are set. In every other case both pins follow their manual request bits. Only one state flop holds the "paused" decision. The thresholds are computed combinationally and clamp at zero and at the FIFO depth. The FIFO, register decoding and the receiver lie outside this block.

Top module: `hys_flow_ctrl`

## Requirements
- R1: While rst_ni is low the paused state is cleared. With automatic control active, the selected pin then reads 0 (asserted), whatever the fill level.
- R2: Automatic control is active only when auto_en_i and mctl_en_i are both 1. While it is inactive, rts_no equals the inverse of man_rts_i and dtr_no equals the inverse of man_dtr_i, combinationally.
- R3: With automatic control active, a clock edge at which fill_lvl_i is at or above the upper threshold (trig_lvl_i + hyst_i) sets the paused state. The selected pin reads 1 after that edge.
- R4: With automatic control active, a clock edge at which fill_lvl_i is at or below the lower threshold (trig_lvl_i - hyst_i), and below the upper threshold, clears the paused state. The selected pin reads 0 after that edge.
- R5: When fill_lvl_i lies strictly between the two thresholds, the paused state keeps its previous value.
- R6: sel_dtr_i = 0 routes the automatic decision to rts_no and leaves dtr_no under manual control. sel_dtr_i = 1 routes it to dtr_no and leaves rts_no under manual control.
- R7: The upper threshold saturates at DEPTH. If trig_lvl_i + hyst_i exceeds DEPTH, pausing happens only when the FIFO is completely full.
- R8: The lower threshold saturates at 0. If hyst_i exceeds trig_lvl_i, resuming happens only when the fill level is 0.
- R9: With hyst_i = 0 both thresholds equal trig_lvl_i, and the pause condition takes priority. A fill equal to the trigger pauses, and a fill one below it resumes.
- R10: Any clock edge at which automatic control is inactive clears the paused state. Re-enabling automatic control with a fill level between the thresholds therefore leaves the pin asserted (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fill_lvl_i | input | CNT_W | Current receive FIFO fill count |
| trig_lvl_i | input | CNT_W | Trigger level |
| hyst_i | input | CNT_W | Hysteresis margin applied on both sides of the trigger |
| auto_en_i | input | 1 | Extended-feature enable for automatic flow control |
| mctl_en_i | input | 1 | Modem-control enable for automatic flow control |
| sel_dtr_i | input | 1 | 0: automatic control drives RTS, 1: drives DTR |
| man_rts_i | input | 1 | Manual RTS request (1 = assert, pin low) |
| man_dtr_i | input | 1 | Manual DTR request (1 = assert, pin low) |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |

## Verification
The bench walks the trigger 48 / margin 8 case through each side of the band. A design with a single threshold would toggle at 41 or 55, and one that compares with the wrong strictness would miss the exact edges at 56 and 40. Triggers near 0 and near the depth probe the clamping: unclamped arithmetic would wrap the lower threshold to a large value and resume too early, or never pause at all. A zero margin checks that pause wins when both thresholds meet. Switching the pin select and dropping one enable while paused exposes a wrong pin mux, or a stale paused state that survives re-enabling.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  typedef enum logic {
    PIN_RTS = 1'b0,
    PIN_DTR = 1'b1
  } pin_sel_e;

  typedef struct packed {
    logic rts_n;
    logic dtr_n;
  } pin_pair_t;
endpackage

// File: rtl/hfc_thresholds.sv
module hfc_thresholds #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] trig_i,
  input  logic [CNT_W-1:0] hyst_i,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W + 1)'(DEPTH);

  logic [CNT_W:0] sum_w;

  always_comb begin
    sum_w = {1'b0, trig_i} + {1'b0, hyst_i};
    hi_o  = (sum_w > DEPTH_X) ? DEPTH_X[CNT_W-1:0] : sum_w[CNT_W-1:0];
    lo_o  = (trig_i >= hyst_i) ? (trig_i - hyst_i) : '0;
  end
endmodule

// File: rtl/hfc_state.sv
module hfc_state #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             pause_o
);
  logic pause_d;

  // pause wins when both thresholds coincide
  always_comb begin
    pause_d = pause_o;
    if (!act_i)              pause_d = 1'b0;
    else if (fill_i >= hi_i) pause_d = 1'b1;
    else if (fill_i <= lo_i) pause_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pause_o <= 1'b0;
    else         pause_o <= pause_d;
  end
endmodule

// File: rtl/hfc_pin_mux.sv
module hfc_pin_mux
  import hfc_pkg::*;
(
  input  logic      act_i,
  input  pin_sel_e  sel_i,
  input  logic      pause_i,
  input  logic      man_rts_i,
  input  logic      man_dtr_i,
  output pin_pair_t pins_o
);
  always_comb begin
    pins_o.rts_n = ~man_rts_i;
    pins_o.dtr_n = ~man_dtr_i;
    if (act_i) begin
      if (sel_i == PIN_DTR) pins_o.dtr_n = pause_i;
      else                  pins_o.rts_n = pause_i;
    end
  end
endmodule

// File: rtl/hys_flow_ctrl.sv
module hys_flow_ctrl
  import hfc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fill_lvl_i,
  input  logic [CNT_W-1:0] trig_lvl_i,
  input  logic [CNT_W-1:0] hyst_i,
  input  logic             auto_en_i,
  input  logic             mctl_en_i,
  input  logic             sel_dtr_i,
  input  logic             man_rts_i,
  input  logic             man_dtr_i,
  output logic             rts_no,
  output logic             dtr_no
);
  logic [CNT_W-1:0] hi_w, lo_w;
  logic             act_w, pause_q;
  pin_pair_t        pins_w;
  pin_sel_e         sel_w;

  assign act_w = auto_en_i & mctl_en_i;
  assign sel_w = pin_sel_e'(sel_dtr_i);

  hfc_thresholds #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thr (
    .trig_i (trig_lvl_i),
    .hyst_i (hyst_i),
    .hi_o   (hi_w),
    .lo_o   (lo_w)
  );

  hfc_state #(.CNT_W(CNT_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act_w),
    .fill_i  (fill_lvl_i),
    .hi_i    (hi_w),
    .lo_i    (lo_w),
    .pause_o (pause_q)
  );

  hfc_pin_mux u_mux (
    .act_i     (act_w),
    .sel_i     (sel_w),
    .pause_i   (pause_q),
    .man_rts_i (man_rts_i),
    .man_dtr_i (man_dtr_i),
    .pins_o    (pins_w)
  );

  assign rts_no = pins_w.rts_n;
  assign dtr_no = pins_w.dtr_n;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] fill_lvl_i,
  input logic [CNT_W-1:0] trig_lvl_i,
  input logic             auto_en_i,
  input logic             mctl_en_i,
  input logic             sel_dtr_i,
  input logic             man_rts_i,
  input logic             man_dtr_i,
  input logic             rts_no,
  input logic             dtr_no,
  input logic [CNT_W-1:0] hi_w,
  input logic [CNT_W-1:0] lo_w,
  input logic             pause_q
);
  logic act, auto_pin;
  assign act      = auto_en_i & mctl_en_i;
  assign auto_pin = sel_dtr_i ? dtr_no : rts_no;

  AST_MANUAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (rts_no == !man_rts_i) && (dtr_no == !man_dtr_i)); // R2

  AST_FULL_PAUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && (fill_lvl_i == CNT_W'(DEPTH)) |=> !act || auto_pin); // R7

  AST_EMPTY_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && (fill_lvl_i == '0) && (trig_lvl_i != '0) |=> !act || !auto_pin); // R8

  AST_HOLD_IN_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && (fill_lvl_i > lo_w) && (fill_lvl_i < hi_w) |=> $stable(pause_q)); // R5

  AST_OTHER_PIN_MANUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> (sel_dtr_i ? (rts_no == !man_rts_i) : (dtr_no == !man_dtr_i))); // R6

  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> !pause_q); // R10

  AST_PAUSE_AT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && (fill_lvl_i >= hi_w) |=> pause_q); // R3
endmodule

bind hys_flow_ctrl hfc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fill_lvl_i (fill_lvl_i),
  .trig_lvl_i (trig_lvl_i),
  .auto_en_i  (auto_en_i),
  .mctl_en_i  (mctl_en_i),
  .sel_dtr_i  (sel_dtr_i),
  .man_rts_i  (man_rts_i),
  .man_dtr_i  (man_dtr_i),
  .rts_no     (rts_no),
  .dtr_no     (dtr_no),
  .hi_w       (hi_w),
  .lo_w       (lo_w),
  .pause_q    (pause_q)
);

// File: tb/tb_hys_flow_ctrl.sv
module tb_hys_flow_ctrl;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] fill_lvl_i = '0, trig_lvl_i = '0, hyst_i = '0;
  logic             auto_en_i = 1'b0, mctl_en_i = 1'b0, sel_dtr_i = 1'b0;
  logic             man_rts_i = 1'b0, man_dtr_i = 1'b0;
  logic             rts_no, dtr_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  hys_flow_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

  // {req, auto_en, mctl_en, sel, man_rts, man_dtr, trig, hyst, fill, exp_rts, exp_dtr}
  typedef struct packed {
    logic [7:0] req;
    logic       ae, me, sel, mr, md;
    logic [7:0] trig, hyst, fill;
    logic       er, ed;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 1,1,0,1,1, 8'd48, 8'd8,  8'd10, 0,0}, // R4 below band, running
    '{8'd5, 1,1,0,1,1, 8'd48, 8'd8,  8'd55, 0,0}, // R5 just below upper
    '{8'd3, 1,1,0,1,1, 8'd48, 8'd8,  8'd56, 1,0}, // R3 reaches upper
    '{8'd5, 1,1,0,1,0, 8'd48, 8'd8,  8'd50, 1,1}, // R5 hold paused, dtr manual
    '{8'd5, 1,1,0,1,0, 8'd48, 8'd8,  8'd41, 1,1}, // R5 just above lower
    '{8'd4, 1,1,0,1,1, 8'd48, 8'd8,  8'd40, 0,0}, // R4 reaches lower
    '{8'd5, 1,1,0,1,1, 8'd48, 8'd8,  8'd50, 0,0}, // R5 hold running
    '{8'd6, 1,1,1,1,1, 8'd48, 8'd8,  8'd60, 0,1}, // R6 dtr selected, pauses
    '{8'd6, 1,1,1,0,1, 8'd48, 8'd8,  8'd45, 1,1}, // R6 rts manual, dtr holds
    '{8'd6, 1,1,1,1,1, 8'd48, 8'd8,  8'd39, 0,0}, // R6 dtr resumes
    '{8'd7, 1,1,0,1,1, 8'd60, 8'd10, 8'd63, 0,0}, // R7 upper clamped at 64
    '{8'd7, 1,1,0,1,1, 8'd60, 8'd10, 8'd64, 1,0}, // R7 full pauses
    '{8'd7, 1,1,0,1,1, 8'd60, 8'd10, 8'd51, 1,0}, // R7 lower = 50 not hit
    '{8'd7, 1,1,0,1,1, 8'd60, 8'd10, 8'd50, 0,0}, // R7 lower hit
    '{8'd8, 1,1,0,1,1, 8'd4,  8'd8,  8'd12, 1,0}, // R8 upper = 12
    '{8'd8, 1,1,0,1,1, 8'd4,  8'd8,  8'd1,  1,0}, // R8 lower clamped, hold
    '{8'd8, 1,1,0,1,1, 8'd4,  8'd8,  8'd0,  0,0}, // R8 empty resumes
    '{8'd9, 1,1,0,1,1, 8'd20, 8'd0,  8'd20, 1,0}, // R9 equal pauses
    '{8'd9, 1,1,0,1,1, 8'd20, 8'd0,  8'd19, 0,0}, // R9 one below resumes
    '{8'd9, 1,1,0,1,1, 8'd20, 8'd0,  8'd20, 1,0}, // R9 pause again
    '{8'd2, 1,0,0,0,1, 8'd20, 8'd0,  8'd20, 1,0}, // R2 mctl off: manual
    '{8'd2, 0,1,0,1,0, 8'd20, 8'd0,  8'd64, 0,1}, // R2 auto off: manual
    '{8'd10,1,1,0,1,1, 8'd20, 8'd8,  8'd20, 0,0}, // R10 re-enable in band
    '{8'd3, 1,1,0,1,1, 8'd20, 8'd8,  8'd28, 1,0}, // R3 pause
    '{8'd10,0,0,0,1,1, 8'd20, 8'd8,  8'd28, 0,0}, // R10 disable clears
    '{8'd10,1,1,0,1,1, 8'd20, 8'd8,  8'd24, 0,0}  // R10 re-enable in band
  };

  task automatic check(input string tag, input logic er, input logic ed);
    n_chk++;
    if (rts_no !== er || dtr_no !== ed) begin
      n_bad++;
      $display("FAIL %s: rts_no=%b dtr_no=%b expected rts_no=%b dtr_no=%b",
               tag, rts_no, dtr_no, er, ed);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds the auto pin asserted even with a full FIFO
    auto_en_i = 1; mctl_en_i = 1; man_rts_i = 1; man_dtr_i = 1;
    trig_lvl_i = 7'd48; hyst_i = 7'd8; fill_lvl_i = 7'd64;
    repeat (3) @(posedge clk_i);
    #1 check("R1 in reset", 1'b0, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1 check("R3 full after reset", 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5 check("R1 async reset", 1'b0, 1'b0);
    @(negedge clk_i) begin rst_ni = 1'b1; fill_lvl_i = 7'd10; end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      auto_en_i  = VECS[i].ae;  mctl_en_i = VECS[i].me; sel_dtr_i = VECS[i].sel;
      man_rts_i  = VECS[i].mr;  man_dtr_i = VECS[i].md;
      trig_lvl_i = VECS[i].trig[CNT_W-1:0];
      hyst_i     = VECS[i].hyst[CNT_W-1:0];
      fill_lvl_i = VECS[i].fill[CNT_W-1:0];
      @(posedge clk_i); #1;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].er, VECS[i].ed);
    end

    // R2: manual path is combinational, no clock needed
    @(negedge clk_i);
    auto_en_i = 0; man_rts_i = 0; man_dtr_i = 0;
    #0.5 check("R2 manual combinational", 1'b1, 1'b1);
    man_dtr_i = 1;
    #0.5 check("R2 manual dtr toggle", 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule